// File: doc/BRIEF.md
# Serial Line Activity Monitor and Driver Power Controller

This block sits between the logic side of a single-channel serial port and its line transceiver. An analog front end reduces the receive line to a two-bit level code. From that code the block keeps a line-activity flag: it drops the flag after the line has rested in the dead band around zero volts for longer than a dwell window, and raises it again once a valid level has been seen for a short qualify window. The transmit driver is enabled, forced on, or powered off from two override pins and that flag. When automatic mode turns the driver back on, a supply-settling delay must pass before the driver output is enabled.

The receive path inverts the line level onto a logic output, which can be switched to high impedance by an enable pin. A three-state power indication and an automatic-shutdown sub-flag report the driver's condition. All three delays are parameters counted in clock cycles.

Top module: `line_pwr_ctl`

## Requirements
- R1: The level code reads 2'b00 dead band, 2'b01 valid low, 2'b10 valid high, 2'b11 indeterminate. Reset clears all counters, drives `line_active` low and leaves the driver disabled.
- R2: `line_active` falls at the clock edge that samples the (DWELL_CYC+1)-th consecutive dead-band code. A shorter dead-band stay leaves it high, and any valid sample restarts the dwell count from zero.
- R3: Indeterminate samples hold both the dwell count and `line_active` unchanged, whether the flag is high or low.
- R4: While `line_active` is low, it rises at the edge that samples the QUAL_CYC-th consecutive valid code. Any non-valid sample restarts this count.
- R5: With `force_off_n` low, the driver is off (`drv_oe`=0, `drv_data`=0), `pwr_state` is 2'b00 and `auto_down` is 0, whatever `force_on`, `tx_bit` and the line do.
- R6: With `force_on` and `force_off_n` both high, `drv_oe` is 1 at once, `drv_data` is the inverse of `tx_bit`, `pwr_state` is 2'b01 and `auto_down` is 0.
- R7: With `force_on` low and `force_off_n` high, `pwr_state` is 2'b10. The driver is enabled only while `line_active` is high and the supply is ready. `auto_down` is high exactly when the driver is disabled in this mode. While enabled, `drv_data` is the inverse of `tx_bit`.
- R8: In automatic mode, with the supply not ready and `line_active` high, `drv_oe` rises at the SUPPLY_CYC-th clock edge after the first edge that sees both conditions. Leaving automatic mode through force-off, or losing line activity, clears supply readiness.
- R9: With `rx_off` high, `rcv_oe` is 0 and `rcv_data` is 0. Otherwise `rcv_oe` is 1 and `rcv_data` is 0 for valid high and 1 for every other code, so an open line reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_code | input | 2 | Classified receive-line level |
| tx_bit | input | 1 | Transmit data bit from the logic side |
| force_on | input | 1 | Keeps the driver on when force_off_n is high |
| force_off_n | input | 1 | Low powers the driver off |
| rx_off | input | 1 | High puts the receiver output in high impedance |
| line_active | output | 1 | High while a valid signal is present on the line |
| drv_data | output | 1 | Driver data value (inverted transmit bit) |
| drv_oe | output | 1 | Driver output enable |
| rcv_data | output | 1 | Receiver logic output value |
| rcv_oe | output | 1 | Receiver output enable |
| pwr_state | output | 2 | 00 off, 01 forced on, 10 automatic |
| auto_down | output | 1 | Driver held off by automatic power-down |

## Verification
On every cycle the assertions check four things. The activity flag falls only after a dead-band sample and rises only after a valid one. An indeterminate sample leaves the flag unchanged. In automatic mode the driver is never enabled while the line is inactive, and it never comes up on the same edge at which the line turns active. The exact cycle counts of the dwell, qualify and supply windows can only be shown by the bench's scenarios. The same holds for the restart of the dwell count by a brief valid level, the hold across indeterminate stretches in both flag states, the renewed supply delay on return from force-off, and the mapping of each override combination to the outputs.

// File: rtl/line_pwr_ctl.sv
module line_pwr_ctl #(
  parameter int DWELL_CYC  = 1500,
  parameter int QUAL_CYC   = 50,
  parameter int SUPPLY_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_code,
  input  logic       tx_bit,
  input  logic       force_on,
  input  logic       force_off_n,
  input  logic       rx_off,
  output logic       line_active,
  output logic       drv_data,
  output logic       drv_oe,
  output logic       rcv_data,
  output logic       rcv_oe,
  output logic [1:0] pwr_state,
  output logic       auto_down
);

  localparam logic [1:0] LV_DEAD = 2'b00;
  localparam logic [1:0] LV_LOW  = 2'b01;
  localparam logic [1:0] LV_HIGH = 2'b10;
  localparam logic [1:0] LV_MID  = 2'b11;

  localparam int DW = $clog2(DWELL_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int SW = $clog2(SUPPLY_CYC + 1);

  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_CYC);
  localparam logic [QW-1:0] QUAL_LAST  = QW'(QUAL_CYC - 1);
  localparam logic [SW-1:0] SUP_LAST   = SW'(SUPPLY_CYC - 1);

  logic [DW-1:0] dwell_cnt;
  logic [QW-1:0] qual_cnt;
  logic [SW-1:0] sup_cnt;
  logic          sup_rdy;

  wire is_valid  = (lvl_code == LV_LOW) || (lvl_code == LV_HIGH);
  wire is_dead   = (lvl_code == LV_DEAD);
  wire auto_mode = force_off_n & ~force_on;
  wire forced    = force_off_n & force_on;

  // line activity: dwell timer on the dead band, qualify timer on valid levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_active <= 1'b0;
      dwell_cnt   <= '0;
      qual_cnt    <= '0;
    end else if (is_valid) begin
      dwell_cnt <= '0;
      if (line_active) begin
        qual_cnt <= '0;
      end else if (qual_cnt == QUAL_LAST) begin
        line_active <= 1'b1;
        qual_cnt    <= '0;
      end else begin
        qual_cnt <= qual_cnt + QW'(1);
      end
    end else if (is_dead) begin
      qual_cnt <= '0;
      if (line_active) begin
        if (dwell_cnt == DWELL_LAST) begin
          line_active <= 1'b0;
          dwell_cnt   <= '0;
        end else begin
          dwell_cnt <= dwell_cnt + DW'(1);
        end
      end
    end else begin
      qual_cnt <= '0;
    end
  end

  // supply settling before the driver is enabled in automatic mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_rdy <= 1'b0;
      sup_cnt <= '0;
    end else if (forced) begin
      sup_rdy <= 1'b1;
      sup_cnt <= '0;
    end else if (auto_mode && line_active && !sup_rdy) begin
      if (sup_cnt == SUP_LAST) begin
        sup_rdy <= 1'b1;
        sup_cnt <= '0;
      end else begin
        sup_cnt <= sup_cnt + SW'(1);
      end
    end else if (!force_off_n || !line_active) begin
      sup_rdy <= 1'b0;
      sup_cnt <= '0;
    end
  end

  assign drv_oe    = forced | (auto_mode & line_active & sup_rdy);
  assign drv_data  = drv_oe & ~tx_bit;
  assign auto_down = auto_mode & ~drv_oe;
  assign pwr_state = !force_off_n ? 2'b00 : (force_on ? 2'b01 : 2'b10);

  assign rcv_oe   = ~rx_off;
  assign rcv_data = rcv_oe & (lvl_code != LV_HIGH);

  assert_fall_dead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_active) |-> $past(lvl_code) == LV_DEAD);

  assert_rise_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_active) |-> ($past(lvl_code) == LV_LOW || $past(lvl_code) == LV_HIGH));

  assert_mid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_code == LV_MID |=> $stable(line_active));

  assert_auto_idle_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !line_active) |-> !drv_oe);

  assert_supply_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_oe) && auto_mode && $past(auto_mode)) |-> $past(line_active));

endmodule

// File: tb/line_pwr_ctl_bench.sv
module line_pwr_ctl_bench;
  localparam int DWELL = 20;
  localparam int QUAL  = 4;
  localparam int SUP   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] lvl_code = 2'b00;
  logic tx_bit = 1'b0, force_on = 1'b0, force_off_n = 1'b1, rx_off = 1'b0;
  logic line_active, drv_data, drv_oe, rcv_data, rcv_oe, auto_down;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  int    exp_q[$];
  int    sel_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  line_pwr_ctl #(.DWELL_CYC(DWELL), .QUAL_CYC(QUAL), .SUPPLY_CYC(SUP)) u_line_pwr_ctl (
    .clk(clk), .rst_n(rst_n), .lvl_code(lvl_code), .tx_bit(tx_bit),
    .force_on(force_on), .force_off_n(force_off_n), .rx_off(rx_off),
    .line_active(line_active), .drv_data(drv_data), .drv_oe(drv_oe),
    .rcv_data(rcv_data), .rcv_oe(rcv_oe), .pwr_state(pwr_state), .auto_down(auto_down));

  function automatic int pick(input int sel);
    case (sel)
      0: return int'(line_active);
      1: return int'(drv_oe);
      2: return int'(drv_data);
      3: return int'(rcv_oe);
      4: return int'(rcv_data);
      5: return int'(pwr_state);
      default: return int'(auto_down);
    endcase
  endfunction

  function automatic string sig_name(input int sel);
    case (sel)
      0: return "line_active";
      1: return "drv_oe";
      2: return "drv_data";
      3: return "rcv_oe";
      4: return "rcv_data";
      5: return "pwr_state";
      default: return "auto_down";
    endcase
  endfunction

  task automatic expect_val(input int sel, input int val, input string tag);
    sel_q.push_back(sel);
    exp_q.push_back(val);
    tag_q.push_back(tag);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations 5 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sel_q.size() > 0) begin
        int s, e, a;
        string t;
        s = sel_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = pick(s);
        checks++;
        if (a != e) begin
          errors++;
          $display("FAIL %s: %s actual %0d expected %0d", t, sig_name(s), a, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_val(0, 0, "R1"); expect_val(1, 0, "R1");
    expect_val(5, 2, "R7"); expect_val(6, 1, "R7");
    expect_val(3, 1, "R9"); expect_val(4, 1, "R9");

    // R4 qualify with a restart
    wait_cyc(1); lvl_code = 2'b10;
    wait_cyc(2); lvl_code = 2'b11;
    wait_cyc(1); lvl_code = 2'b10;
    expect_val(4, 0, "R9");
    wait_cyc(QUAL - 1); expect_val(0, 0, "R4");
    wait_cyc(1);        expect_val(0, 1, "R4");

    // R8 supply delay after activity returns
    wait_cyc(SUP - 1); expect_val(1, 0, "R8"); expect_val(6, 1, "R7");
    wait_cyc(1);       expect_val(1, 1, "R8"); expect_val(6, 0, "R7");
    tx_bit = 1'b1;     expect_val(2, 0, "R7");
    wait_cyc(1); tx_bit = 1'b0; expect_val(2, 1, "R7");

    // R9 receiver
    wait_cyc(1); lvl_code = 2'b01; expect_val(4, 1, "R9");
    wait_cyc(1); rx_off = 1'b1; expect_val(3, 0, "R9"); expect_val(4, 0, "R9");
    wait_cyc(1); rx_off = 1'b0; expect_val(3, 1, "R9");

    // R2 dwell with a restart by a valid level
    wait_cyc(1); lvl_code = 2'b00;
    wait_cyc(DWELL); expect_val(0, 1, "R2");
    lvl_code = 2'b01;
    wait_cyc(1); lvl_code = 2'b00;
    wait_cyc(DWELL); expect_val(0, 1, "R2");
    wait_cyc(1); expect_val(0, 0, "R2"); expect_val(1, 0, "R7"); expect_val(6, 1, "R7");

    // R3 indeterminate holds count and flag
    lvl_code = 2'b10;
    wait_cyc(QUAL); expect_val(0, 1, "R4");
    lvl_code = 2'b00;
    wait_cyc(10); lvl_code = 2'b11;
    wait_cyc(30); expect_val(0, 1, "R3");
    lvl_code = 2'b00;
    wait_cyc(10); expect_val(0, 1, "R3");
    wait_cyc(1);  expect_val(0, 0, "R3");
    lvl_code = 2'b11;
    wait_cyc(5); expect_val(0, 0, "R3");

    // R6 forced on
    lvl_code = 2'b00;
    wait_cyc(1); force_on = 1'b1; tx_bit = 1'b1;
    expect_val(1, 1, "R6"); expect_val(2, 0, "R6");
    expect_val(5, 1, "R6"); expect_val(6, 0, "R6");

    // R5 forced off overrides everything
    wait_cyc(1); force_off_n = 1'b0; lvl_code = 2'b10;
    wait_cyc(QUAL + 2);
    expect_val(0, 1, "R5"); expect_val(1, 0, "R5"); expect_val(2, 0, "R5");
    expect_val(5, 0, "R5"); expect_val(6, 0, "R5");

    // R8 renewed supply delay on return to automatic mode
    wait_cyc(1); force_on = 1'b0; force_off_n = 1'b1;
    expect_val(5, 2, "R8"); expect_val(1, 0, "R8");
    wait_cyc(SUP - 1); expect_val(1, 0, "R8");
    wait_cyc(1);       expect_val(1, 1, "R8"); expect_val(2, 0, "R8");

    wait_cyc(2);
    #8;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule